// File: doc/BRIEF.md
# Asynchronous / Clocked Serial Receiver with Re-armed Holding Register

This block takes a serial bit stream on one input and turns it into bytes that software reads through a small four-register interface. In asynchronous mode a 16x oversampling deframer assembles each character in its own shift register. The character is then copied into a one-entry holding register, so software can read the previous character while the next one is still arriving. Software releases the holding register by writing the arm bit, not by reading it. A character that completes while the block is not armed is flagged as an overrun.

In clocked mode an external bit clock shifts eight bits in. The arm bit starts one capture and drops when it is done. The data register then returns the shift register directly. Each completed character raises a one-cycle interrupt pulse in either mode.

Register map (`reg_addr_i`):
- 0 CTRL: bit0 enable, bit1 clocked mode, bit2 seven-bit characters, bit3 parity on, bit4 odd parity, bit5 arm (write 1 to arm, read back as status).
- 1 STAT: bit0 overrun, bit1 parity error, bit2 stop-bit error. Each bit clears when 1 is written to it.
- 2 DATA: the received character (read only).
- 3 BAUD: the tick divider. There is one oversample tick every BAUD+1 clocks.

Top module: `uart_rx_rearm`

## Requirements
- R1: After reset, CTRL and STAT read 0x00 and `irq_o` is low.
- R2: In asynchronous mode the line is sampled on ticks of the divider. A start bit is accepted at mid-bit. Data bits are taken LSB first at their centres, and the completed character appears at DATA.
- R3: Every completed character gives exactly one `irq_o` pulse, one clock wide.
- R4: Writing CTRL with bit5=1 and bit0=1 sets the arm bit, which reads back as CTRL bit5. An asynchronous completion clears it.
- R5: When a character completes while the arm bit is 0, STAT bit0 is set and the new character replaces the holding register. The arm bit stays 0.
- R6: Writing 1 to a STAT bit clears it. Writing 0 leaves it unchanged.
- R7: While CTRL bit0 is 0, the overrun flag and the arm bit are held at 0. Writes that try to set the arm bit are ignored, and no characters are received.
- R8: With seven-bit characters and parity enabled, DATA bit7 reads 0. A parity mismatch (even, or odd when CTRL bit4=1) sets STAT bit1.
- R9: DATA keeps the previous character while the next one is being shifted in, until that one completes.
- R10: In clocked mode (CTRL bit1=1), a set arm bit captures 8 bits, LSB first, on rising edges of `sclk_i`. DATA then reads the shift register, the arm bit clears and `irq_o` pulses. Edges that arrive while the arm bit is 0 shift nothing.
- R11: A low pulse shorter than half a bit is rejected as a false start. It gives no interrupt and leaves the arm bit unchanged.
- R12: A stop bit sampled low sets STAT bit2, and the character is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial data line (asynchronous) |
| sclk_i | input | 1 | External bit clock for clocked mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational from address) |
| irq_o | output | 1 | Character-complete pulse |

## Verification
Register writes take effect at the next clock edge, and reads are combinational, so every register check samples at a falling edge after its write has landed. A character completes at the centre of its stop bit. In asynchronous mode that is roughly nine and a half bit times of 16·(BAUD+1) clocks after the start edge, plus two synchronizer stages. The bench therefore drives the whole frame and then waits twenty idle clocks before checking the flags, DATA or the interrupt count. In clocked mode a result follows the last rising edge of `sclk_i` after three clocks, and the bench waits at least eight. The mid-frame check of DATA samples about five bit times into the following frame, well before that frame can complete.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_BAUD = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic seven;
    logic clocked;
    logic en;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;

  localparam int unsigned ARM_BIT = 5;
endpackage

// File: rtl/rxr_baud_gen.sv
module rxr_baud_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rxr_async_deframer.sv
module rxr_async_deframer
  import rxr_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              seven_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  localparam int unsigned OS_W  = $clog2(OSR);
  localparam int unsigned BIT_W = $clog2(DATA_W + 1);
  localparam logic [OS_W-1:0]  HALF = OS_W'(OSR/2 - 1);
  localparam logic [OS_W-1:0]  LAST = OS_W'(OSR - 1);

  rx_state_e         state_q;
  logic [OS_W-1:0]   os_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_acc_q;
  logic              par_bad_q;
  logic [BIT_W-1:0]  last_bit;

  assign last_bit = seven_i ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1);
  // seven-bit characters end up in the top bits; the spare bit reads 0
  assign data_o   = seven_i ? {1'b0, sh_q[DATA_W-1:1]} : sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      os_q      <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      par_acc_q <= 1'b0;
      par_bad_q <= 1'b0;
      done_o    <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else if (!run_i) begin
      state_q <= S_IDLE;
      os_q    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          S_IDLE: begin
            if (!rx_i) begin
              state_q <= S_START;
              os_q    <= '0;
            end
          end
          S_START: begin
            if (os_q == HALF) begin
              os_q      <= '0;
              bit_q     <= '0;
              par_acc_q <= 1'b0;
              par_bad_q <= 1'b0;
              state_q   <= rx_i ? S_IDLE : S_DATA;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          S_DATA: begin
            if (os_q == LAST) begin
              os_q      <= '0;
              sh_q      <= {rx_i, sh_q[DATA_W-1:1]};
              par_acc_q <= par_acc_q ^ rx_i;
              bit_q     <= bit_q + 1'b1;
              if (bit_q == last_bit) state_q <= par_en_i ? S_PAR : S_STOP;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          S_PAR: begin
            if (os_q == LAST) begin
              os_q      <= '0;
              par_bad_q <= (par_acc_q ^ rx_i) != par_odd_i;
              state_q   <= S_STOP;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          S_STOP: begin
            if (os_q == LAST) begin
              os_q      <= '0;
              done_o    <= 1'b1;
              frm_err_o <= !rx_i;
              par_err_o <= par_en_i && par_bad_q;
              state_q   <= S_IDLE;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxr_sync_shifter.sv
module rxr_sync_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [2:0]       sclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  // sdi_i comes through a two-stage synchronizer aligned with sclk_q[1]
  assign rise = sclk_q[1] && !sclk_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      cnt_q  <= '0;
      data_o <= '0;
      done_o <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      done_o <= 1'b0;
      if (!run_i) begin
        cnt_q <= '0;
      end else if (rise) begin
        data_o <= {sdi_i, data_o[DATA_W-1:1]};
        if (cnt_q == CNT_W'(DATA_W - 1)) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_rearm.sv
module uart_rx_rearm
  import rxr_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_i,
  input  logic        sclk_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        irq_o
);
  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  baud_q;
  logic [DATA_W-1:0] buf_q;
  logic              arm_q, ovr_q, perr_q, ferr_q;
  logic [1:0]        rx_sync_q;
  logic              rx_s;

  logic              we_ctrl, we_stat, arm_set;
  logic              async_run, sync_run, tick;
  logic              a_done_raw, a_perr, a_ferr, s_done_raw;
  logic              a_done, s_done, done_any;
  logic [DATA_W-1:0] a_data, s_data;
  logic              ctrl_en, ctrl_seven;

  assign rx_s       = rx_sync_q[1];
  assign we_ctrl    = reg_we_i && (reg_addr_i == REG_CTRL);
  assign we_stat    = reg_we_i && (reg_addr_i == REG_STAT);
  assign arm_set    = we_ctrl && reg_wdata_i[ARM_BIT] && reg_wdata_i[0];
  assign async_run  = ctrl_q.en && !ctrl_q.clocked;
  assign sync_run   = ctrl_q.en && ctrl_q.clocked && arm_q;
  assign a_done     = a_done_raw && async_run;
  assign s_done     = s_done_raw && ctrl_q.en && ctrl_q.clocked;
  assign done_any   = a_done || s_done;
  assign irq_o      = done_any;
  assign ctrl_en    = ctrl_q.en;
  assign ctrl_seven = ctrl_q.seven;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_sync_q <= 2'b11;
    else         rx_sync_q <= {rx_sync_q[0], rx_i};
  end

  rxr_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (async_run),
    .div_i  (baud_q),
    .tick_o (tick)
  );

  rxr_async_deframer #(.OSR(OSR), .DATA_W(DATA_W)) u_deframe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (async_run),
    .tick_i    (tick),
    .rx_i      (rx_s),
    .seven_i   (ctrl_q.seven),
    .par_en_i  (ctrl_q.par_en),
    .par_odd_i (ctrl_q.par_odd),
    .done_o    (a_done_raw),
    .data_o    (a_data),
    .par_err_o (a_perr),
    .frm_err_o (a_ferr)
  );

  rxr_sync_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (sync_run),
    .sclk_i (sclk_i),
    .sdi_i  (rx_s),
    .done_o (s_done_raw),
    .data_o (s_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      baud_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == REG_CTRL) ctrl_q <= ctrl_t'(reg_wdata_i[4:0]);
      if (reg_addr_i == REG_BAUD) baud_q <= DIV_W'(reg_wdata_i);
    end
  end

  // arm: completion clears, software write sets (write wins on a tie)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
    end else begin
      if (!ctrl_q.en)    arm_q <= 1'b0;
      else if (done_any) arm_q <= 1'b0;
      if (arm_set)       arm_q <= 1'b1;
    end
  end

  // overrun is judged against the arm state before any same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (we_stat && reg_wdata_i[0]) ovr_q  <= 1'b0;
      if (we_stat && reg_wdata_i[1]) perr_q <= 1'b0;
      if (we_stat && reg_wdata_i[2]) ferr_q <= 1'b0;
      if (a_done && !arm_q) ovr_q  <= 1'b1;
      if (a_done && a_perr) perr_q <= 1'b1;
      if (a_done && a_ferr) ferr_q <= 1'b1;
      if (!ctrl_q.en)       ovr_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     buf_q <= '0;
    else if (a_done) buf_q <= a_data;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: reg_rdata_o = {2'b00, arm_q, ctrl_q.par_odd, ctrl_q.par_en,
                               ctrl_q.seven, ctrl_q.clocked, ctrl_q.en};
      REG_STAT: reg_rdata_o = {5'b0, ferr_q, perr_q, ovr_q};
      REG_DATA: reg_rdata_o = 8'(ctrl_q.clocked ? s_data : buf_q);
      REG_BAUD: reg_rdata_o = 8'(baud_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[7:6];
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              seven_i,
  input logic              arm_i,
  input logic              arm_set_i,
  input logic              a_done_i,
  input logic              done_any_i,
  input logic              ovr_i,
  input logic              irq_i,
  input logic [DATA_W-1:0] a_data_i,
  input logic [DATA_W-1:0] buf_i
);
  // R5
  ovr_rise_on_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_i) |-> $past(a_done_i && !arm_i));

  // R3
  irq_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  // R4
  arm_clear_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_any_i && arm_i && !arm_set_i) |=> !arm_i);

  // R7
  disabled_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> (!arm_i && !ovr_i));

  // R2
  buf_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_done_i |=> (buf_i == $past(a_data_i)));

  // R8
  seven_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_done_i && seven_i) |=> !buf_i[DATA_W-1]);
endmodule

bind uart_rx_rearm rxr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (ctrl_en),
  .seven_i    (ctrl_seven),
  .arm_i      (arm_q),
  .arm_set_i  (arm_set),
  .a_done_i   (a_done),
  .done_any_i (done_any),
  .ovr_i      (ovr_q),
  .irq_i      (irq_o),
  .a_data_i   (a_data),
  .buf_i      (buf_q)
);

// File: tb/uart_rx_rearm_bench.sv
`timescale 1ns/1ps
module uart_rx_rearm_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       sclk = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int total = 0;
  int fails = 0;
  int irq_cnt = 0;
  int cur_div = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_rearm u_uart_rx_rearm (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_i        (rx),
    .sclk_i      (sclk),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drive_bit(input bit v);
    rx = v;
    repeat (16 * (cur_div + 1)) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                            input bit pbit, input bit stop_v);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (pen) drive_bit(pbit);
    drive_bit(stop_v);
    rx = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic send_clocked(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rx = d[i];
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    rx = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 stat", v, 8'h00);
    chk("R1 irq", 8'(irq), 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    int c0;
    wr(2'd3, 8'd0); cur_div = 0;
    wr(2'd0, 8'h21);
    rd(2'd0, v); chk("R4 armed", v, 8'h21);
    c0 = irq_cnt;
    send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b1);
    rd(2'd2, v); chk("R2 data", v, 8'hA5);
    chk("R3 one irq", 8'(irq_cnt - c0), 8'd1);
    rd(2'd0, v); chk("R4 arm cleared", v, 8'h01);
    rd(2'd1, v); chk("R2 stat clean", v, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); chk("R5 overrun set", v, 8'h01);
    rd(2'd2, v); chk("R5 new data kept", v, 8'h3C);
    rd(2'd0, v); chk("R5 arm stays 0", v, 8'h01);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R6 write0 no effect", v, 8'h01);
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R6 write1 clears", v, 8'h00);
  endtask

  task automatic t_read_during();
    logic [7:0] v;
    wr(2'd0, 8'h21);
    send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1);
    wr(2'd0, 8'h21);
    fork
      send_frame(8'h22, 8, 1'b0, 1'b0, 1'b1);
      begin
        repeat (16 * 5) @(negedge clk);
        rd(2'd2, v); chk("R9 old data mid-frame", v, 8'h11);
      end
    join
    rd(2'd2, v); chk("R9 new data", v, 8'h22);
    rd(2'd1, v); chk("R9 no overrun when rearmed", v, 8'h00);
  endtask

  task automatic t_seven();
    logic [7:0] v;
    wr(2'd3, 8'd1); cur_div = 1;
    wr(2'd0, 8'h2D);
    send_frame(8'h55, 7, 1'b1, ^(8'h55 & 8'h7F), 1'b1);
    rd(2'd2, v); chk("R8 seven-bit data", v, 8'h55);
    rd(2'd1, v); chk("R8 good parity", v, 8'h00);
    wr(2'd0, 8'h2D);
    send_frame(8'h7F, 7, 1'b1, 1'b0, 1'b1);
    rd(2'd2, v); chk("R8 bit7 zero", v, 8'h7F);
    rd(2'd1, v); chk("R8 parity error", v, 8'h02);
    wr(2'd1, 8'h02);
  endtask

  task automatic t_framing();
    logic [7:0] v;
    wr(2'd0, 8'h21);
    send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    rd(2'd1, v); chk("R12 stop error", v, 8'h04);
    rd(2'd2, v); chk("R12 data delivered", v, 8'h5A);
    wr(2'd1, 8'h04);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    int c0;
    wr(2'd0, 8'h21);
    c0 = irq_cnt;
    @(negedge clk); rx = 1'b0;
    repeat (4) @(negedge clk); rx = 1'b1;
    repeat (400) @(negedge clk);
    chk("R11 no irq", 8'(irq_cnt - c0), 8'd0);
    rd(2'd0, v); chk("R11 arm kept", v, 8'h21);
  endtask

  task automatic t_disable();
    logic [7:0] v;
    int c0;
    send_frame(8'h01, 8, 1'b0, 1'b0, 1'b1);
    send_frame(8'h02, 8, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); chk("R5 overrun before disable", v, 8'h01);
    wr(2'd0, 8'h00);
    rd(2'd1, v); chk("R7 overrun cleared", v, 8'h00);
    wr(2'd0, 8'h20);
    rd(2'd0, v); chk("R7 arm ignored", v, 8'h00);
    c0 = irq_cnt;
    send_frame(8'h99, 8, 1'b0, 1'b0, 1'b1);
    chk("R7 no reception", 8'(irq_cnt - c0), 8'd0);
  endtask

  task automatic t_clocked();
    logic [7:0] v;
    int c0;
    wr(2'd0, 8'h23);
    rd(2'd0, v); chk("R10 armed", v, 8'h23);
    c0 = irq_cnt;
    send_clocked(8'hC3);
    rd(2'd2, v); chk("R10 data", v, 8'hC3);
    rd(2'd0, v); chk("R10 arm cleared", v, 8'h03);
    chk("R10 irq", 8'(irq_cnt - c0), 8'd1);
    send_clocked(8'hFF);
    rd(2'd2, v); chk("R10 idle edges ignored", v, 8'hC3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_overrun();
    t_read_during();
    t_seven();
    t_framing();
    t_glitch();
    t_disable();
    t_clocked();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule